// File: doc/BRIEF.md
# Exponent-Mantissa Rate Tick Generator

This block produces the timing strobes that a serial transmitter or receiver needs: a bit-rate tick and a mid-bit tick for sampling. The system clock is divided in two stages. A power-of-two prescaler, chosen by a 4-bit exponent code, feeds an 11-bit mantissa counter. The divisor is therefore a small floating-point number. High bit rates get fine steps from the mantissa, and the exponent still reaches very low rates. At 160 MHz, the largest divisor of 256 x 2048 gives roughly 305 bit/s.

Configuration is a single-cycle write of the exponent and mantissa fields. The write restarts both counters, so the old and new settings never mix into a shortened period. Divisors below three system clocks are raised to three. All pins are plain control and status signals. There is no data stream, so there is no valid/ready handshake and no back-pressure. The tick outputs are one-cycle pulses that a consumer samples on the clock edge. One instance can serve both the transmit and receive paths when they share a rate.

Top module: `rate_tick_gen`

## Requirements
- R1: Exponent codes 0 to 8 select a prescale of 2 to the power of the code. Codes 9 to 15 behave exactly like code 8, which is a prescale of 256.
- R2: A mantissa field value m gives a factor of m+1, from 1 to 2048. The bit period D, in system clocks, is the prescale times (m+1).
- R3: When the product in R2 is below 3, the bit period is 3 clocks. This covers exponent 0 with mantissa 0 or 1, and exponent 1 with mantissa 0.
- R4: Offset 0 is the first clock cycle after a configuration write edge or after reset release. bit_tick is high for exactly one cycle at offset D-1 of every period of D cycles, and low otherwise.
- R5: half_tick is high for exactly one cycle at offset floor(D/2) of every period, and low otherwise.
- R6: A configuration write takes effect at once, even in the middle of a period. The first bit_tick under the new setting comes D_new cycles after the write edge, with no tick in between.
- R7: In any cycle in which cfg_we is high, both bit_tick and half_tick are low.
- R8: While rst_n is low, both ticks are low. After release, the block runs with the exponent RST_EXP and mantissa RST_MANT. With the defaults 0 and 9 the bit period is 10.
- R9: bit_tick and half_tick are never high in the same cycle, and bit_tick is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe; restarts both counters |
| cfg_exp | input | 4 | Exponent code for the power-of-two prescaler |
| cfg_mant | input | 11 | Mantissa field; the factor is this value plus one |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| half_tick | output | 1 | One-cycle pulse at the middle of each bit period |

## Verification
The bound checker runs its own phase counter from the written fields. On every cycle it checks that each tick appears exactly at its offset (R4, R5, R6), that writes mask both ticks (R7), and that the two pulses stay apart (R9). Exponent clamping, the minimum-divisor rule, the reset defaults and restarts in the middle of a period are shown only by the bench scenarios. These scenarios compare whole tick streams against periods computed from the field values, for directed corner settings and for seeded random ones.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int EXP_W   = 4;
  localparam int MANT_W  = 11;
  localparam int MAX_EXP = 8;
  localparam int MIN_DIV = 3;
  localparam int PRE_W   = MAX_EXP;
  localparam int DIV_W   = MANT_W + 1 + MAX_EXP;

  typedef struct packed {
    logic [EXP_W-1:0]  exp;
    logic [MANT_W-1:0] mant;
  } rate_cfg_t;

  // Bit period in system clocks for an already limited exponent.
  function automatic logic [DIV_W-1:0] period_of(logic [EXP_W-1:0] e, logic [MANT_W-1:0] m);
    return (DIV_W'(m) + DIV_W'(1)) << e;
  endfunction

  // Limit the exponent code and raise tiny divisors to the minimum.
  function automatic rate_cfg_t limit_cfg(logic [EXP_W-1:0] e, logic [MANT_W-1:0] m);
    rate_cfg_t c;
    c.exp  = (e > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : e;
    c.mant = m;
    if (period_of(c.exp, c.mant) < DIV_W'(MIN_DIV)) begin
      c.exp  = '0;
      c.mant = MANT_W'(MIN_DIV - 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rtg_cfg.sv
module rtg_cfg
  import rtg_pkg::*;
#(
  parameter int RST_EXP  = 0,
  parameter int RST_MANT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EXP_W-1:0]  wr_exp,
  input  logic [MANT_W-1:0] wr_mant,
  output rate_cfg_t         cfg_q
);
  localparam rate_cfg_t RST_CFG = limit_cfg(EXP_W'(RST_EXP), MANT_W'(RST_MANT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= RST_CFG;
    else if (wr_en) cfg_q <= limit_cfg(wr_exp, wr_mant);
  end
endmodule

// File: rtl/rtg_prescale.sv
module rtg_prescale
  import rtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_code,
  output logic [PRE_W-1:0] pre_cnt,
  output logic [PRE_W-1:0] pre_mid,
  output logic             pre_strobe
);
  logic [PRE_W:0]   ratio;
  logic [PRE_W-1:0] pre_last;

  assign ratio      = (PRE_W+1)'(1) << exp_code;
  assign pre_last   = PRE_W'(ratio - (PRE_W+1)'(1));
  assign pre_mid    = PRE_W'(ratio >> 1);
  assign pre_strobe = (pre_cnt == pre_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pre_cnt <= '0;
    else if (restart || pre_strobe) pre_cnt <= '0;
    else                            pre_cnt <= pre_cnt + PRE_W'(1);
  end
endmodule

// File: rtl/rtg_mant.sv
module rtg_mant
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              pre_strobe,
  input  logic [PRE_W-1:0]  pre_cnt,
  input  logic [PRE_W-1:0]  pre_mid,
  input  logic [MANT_W-1:0] mant,
  output logic              bit_tick,
  output logic              half_tick
);
  logic [MANT_W-1:0] mant_cnt;
  logic [MANT_W:0]   factor;
  logic [MANT_W-1:0] half_cnt;
  logic [PRE_W-1:0]  half_pre;
  logic              wrap;

  assign factor   = {1'b0, mant} + (MANT_W+1)'(1);
  assign half_cnt = MANT_W'(factor >> 1);
  // Odd factor: the midpoint falls halfway through a prescale slot.
  assign half_pre = factor[0] ? pre_mid : '0;
  assign wrap     = pre_strobe && (mant_cnt == mant);

  assign bit_tick  = !restart && wrap;
  assign half_tick = !restart && (mant_cnt == half_cnt) && (pre_cnt == half_pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               mant_cnt <= '0;
    else if (restart || wrap) mant_cnt <= '0;
    else if (pre_strobe)      mant_cnt <= mant_cnt + MANT_W'(1);
  end
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import rtg_pkg::*;
#(
  parameter int RST_EXP  = 0,
  parameter int RST_MANT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [EXP_W-1:0]  cfg_exp,
  input  logic [MANT_W-1:0] cfg_mant,
  output logic              bit_tick,
  output logic              half_tick
);
  rate_cfg_t        cur_cfg;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mid;
  logic             pre_strobe;

  rtg_cfg #(.RST_EXP(RST_EXP), .RST_MANT(RST_MANT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we),
    .wr_exp(cfg_exp), .wr_mant(cfg_mant), .cfg_q(cur_cfg)
  );

  rtg_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .exp_code(cur_cfg.exp),
    .pre_cnt(pre_cnt), .pre_mid(pre_mid), .pre_strobe(pre_strobe)
  );

  rtg_mant u_mant (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we), .pre_strobe(pre_strobe),
    .pre_cnt(pre_cnt), .pre_mid(pre_mid), .mant(cur_cfg.mant),
    .bit_tick(bit_tick), .half_tick(half_tick)
  );
endmodule

// File: rtl/rate_tick_gen_chk.sv
module rate_tick_gen_chk
  import rtg_pkg::*;
#(
  parameter int RST_EXP  = 0,
  parameter int RST_MANT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [EXP_W-1:0]  cfg_exp,
  input logic [MANT_W-1:0] cfg_mant,
  input logic              bit_tick,
  input logic              half_tick
);
  localparam rate_cfg_t RST_CFG = limit_cfg(EXP_W'(RST_EXP), MANT_W'(RST_MANT));

  logic [DIV_W-1:0] per;
  logic [DIV_W-1:0] phase;
  rate_cfg_t        nxt;

  assign nxt = limit_cfg(cfg_exp, cfg_mant);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per   <= period_of(RST_CFG.exp, RST_CFG.mant);
      phase <= '0;
    end else if (cfg_we) begin
      per   <= period_of(nxt.exp, nxt.mant);
      phase <= '0;
    end else if (phase == per - DIV_W'(1)) begin
      phase <= '0;
    end else begin
      phase <= phase + DIV_W'(1);
    end
  end

  p_bit_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (phase == per - DIV_W'(1)));
  p_bit_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && phase == per - DIV_W'(1)) |-> bit_tick);
  p_half_at_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> (phase == (per >> 1)));
  p_half_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && phase == (per >> 1)) |-> half_tick);
  p_write_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (!bit_tick && !half_tick));
  p_ticks_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && half_tick));
  p_no_double_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

bind rate_tick_gen rate_tick_gen_chk #(.RST_EXP(RST_EXP), .RST_MANT(RST_MANT)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_exp(cfg_exp),
  .cfg_mant(cfg_mant), .bit_tick(bit_tick), .half_tick(half_tick)
);

// File: tb/test_rate_tick_gen.sv
module test_rate_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_exp = '0;
  logic [10:0] cfg_mant = '0;
  logic        bit_tick, half_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  rate_tick_gen i_rate_tick_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_exp(cfg_exp),
    .cfg_mant(cfg_mant), .bit_tick(bit_tick), .half_tick(half_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Expected bit period from R1, R2, R3.
  function automatic int exp_period(int e, int m);
    int ee = (e > 8) ? 8 : e;
    int d  = (m + 1) << ee;
    return (d < 3) ? 3 : d;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Sample n cycles starting at offset 0 (already at that negedge).
  task automatic watch(int d, int n, string tag);
    int bit_err = 0, half_err = 0, both = 0, bits = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      if (bit_tick !== ((k % d) == d - 1)) bit_err++;
      if (half_tick !== ((k % d) == d / 2)) half_err++;
      if (bit_tick && half_tick) both++;
      if (bit_tick) bits++;
    end
    check(bit_err == 0, {tag, " R4 bit_tick offsets"}, bit_err, 0);
    check(half_err == 0, {tag, " R5 half_tick offsets"}, half_err, 0);
    check(both == 0, {tag, " R9 coincident ticks"}, both, 0);
    check(bits == n / d, {tag, " R4 bit_tick count"}, bits, n / d);
  endtask

  // Write at a negedge; n==0 means two periods less one cycle, so the
  // following write lands on the cycle where the old bit_tick is due.
  task automatic run_cfg(int e, int m, int n, string tag);
    int d = exp_period(e, m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_exp = 4'(e); cfg_mant = 11'(m);
    #1;
    check(!bit_tick && !half_tick, {tag, " R7 ticks during write"},
          int'({bit_tick, half_tick}), 0);
    @(negedge clk);
    cfg_we = 1'b0;
    watch(d, (n == 0) ? 2 * d - 1 : n, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check(!bit_tick && !half_tick, "R8 ticks low in reset", int'({bit_tick, half_tick}), 0);
    rst_n = 1'b1;
    watch(10, 19, "R8 default period 10");

    run_cfg(0, 2, 0, "R3 e0 m2 period 3");
    run_cfg(0, 0, 0, "R3 e0 m0 clamp to 3");
    run_cfg(0, 1, 0, "R3 e0 m1 clamp to 3");
    run_cfg(1, 0, 0, "R3 e1 m0 clamp to 3");
    run_cfg(1, 1, 0, "R2 e1 m1 period 4");
    run_cfg(2, 2, 0, "R2 e2 m2 period 12");
    run_cfg(8, 0, 0, "R1 e8 m0 period 256");
    run_cfg(15, 0, 0, "R1 e15 acts as e8");
    run_cfg(11, 2, 0, "R1 e11 m2 period 768");
    run_cfg(0, 2047, 0, "R2 e0 m2047 period 2048");
    run_cfg(0, 99, 37, "R6 partial period");
    run_cfg(2, 4, 0, "R6 restart mid period");
    run_cfg(3, 6, 45, "R6 partial period");
    run_cfg(0, 4, 0, "R6 restart mid period");

    for (int i = 0; i < 30; i++) begin
      int e  = int'($urandom % 16);
      int ee = (e > 8) ? 8 : e;
      int m  = int'($urandom % (1024 >> ee));
      run_cfg(e, m, 0, "R2 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule